// File: doc/BRIEF.md
# Shared-Bus Register File Card

This block is the general-purpose register store for a processor whose function cards share one backplane bus. Each cycle the bus carries three 5-bit selects: two operand-source selects (A and B) and one result-destination select (Y). It also carries three 32-bit data lanes. The card holds 31 physical 32-bit registers, addressed by indices 1 to 31. No storage exists behind index 0.

A select of zero is not a read of a constant-zero register. It tells this card to stay off that lane, so that another card can drive the operand or consume the result. Bus drive is modelled with a data value and an output-enable for each source lane, not with tri-states. Reads are combinational. The Y lane is captured into the addressed register on the rising clock edge.

Top module: `regfile_card`

## Requirements
- R1: On a rising clock edge with `y_sel_i` in 1..31, register `y_sel_i` takes the value of `y_data_i`. Each of the 31 indices addresses its own distinct storage.
- R2: `a_oe_o` is 1 exactly when `a_sel_i` is nonzero, and `b_oe_o` is 1 exactly when `b_sel_i` is nonzero.
- R3: While a lane's output-enable is 0, its data output is all zeros.
- R4: With `y_sel_i` equal to 0, a clock edge leaves every register unchanged, whatever value `y_data_i` carries.
- R5: Reads are combinational. A change of a source select shows the addressed register's content on that lane in the same cycle, with no clock edge needed.
- R6: When the destination equals a source in the same cycle, that source lane shows the old content before the edge. The new value appears after the edge.
- R7: Driving `rst_ni` low clears all 31 registers to zero at once, without waiting for a clock edge.
- R8: The A and B ports read independently. They may address the same register or different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_sel_i | input | 5 | A-operand source select, 0 = not this card |
| b_sel_i | input | 5 | B-operand source select, 0 = not this card |
| y_sel_i | input | 5 | Result destination select, 0 = not this card |
| y_data_i | input | 32 | Result lane |
| a_data_o | output | 32 | A-operand lane value |
| a_oe_o | output | 1 | Card drives the A lane |
| b_data_o | output | 32 | B-operand lane value |
| b_oe_o | output | 1 | Card drives the B lane |

## Verification
Every index from 1 to 31 is written with an arithmetic pattern that is distinct for each index. All of them are then read back on A in ascending order and on B in descending order. This separates aliased addresses and a port that copies the other port. The zero select is exercised on both source lanes and on the destination. A Y write with select 0 and a conspicuous data value, followed by a full read-back, would expose any stray capture. A same-register read and write is checked on both sides of the edge. An asynchronous reset asserted between edges shows whether clearing waits for the clock.

// File: rtl/regcard_pkg.sv
package regcard_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned SEL_W_DEF  = 5;

  typedef enum logic [0:0] {
    LANE_RELEASED = 1'b0,
    LANE_DRIVEN   = 1'b1
  } lane_state_e;
endpackage

// File: rtl/rc_wr_decode.sv
module rc_wr_decode #(
  parameter int unsigned SEL_W = 5,
  localparam int unsigned NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]    sel_i,
  output logic [NUM_REGS-1:0] we_o
);
  // Slot i holds architectural index i+1. Index 0 matches no slot.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign we_o[i] = (sel_i == SEL_W'(i + 1));
  end
endmodule

// File: rtl/rc_reg_array.sv
module rc_reg_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5,
  localparam int unsigned NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REGS-1:0]            we_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_o[i] <= '0;
      else if (we_i[i]) regs_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/rc_read_port.sv
module rc_read_port
  import regcard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5,
  localparam int unsigned NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               data_o,
  output logic                            oe_o
);
  lane_state_e      state;
  logic [SEL_W-1:0] slot;

  always_comb begin
    state  = (sel_i != '0) ? LANE_DRIVEN : LANE_RELEASED;
    slot   = sel_i - SEL_W'(1);
    oe_o   = (state == LANE_DRIVEN);
    data_o = '0;
    // Released lane reads as zero so a wired-OR bus stays clean.
    if (state == LANE_DRIVEN) data_o = regs_i[slot];
  end
endmodule

// File: rtl/regfile_card.sv
module regfile_card #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  a_sel_i,
  input  logic [SEL_W-1:0]  b_sel_i,
  input  logic [SEL_W-1:0]  y_sel_i,
  input  logic [DATA_W-1:0] y_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_oe_o,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_oe_o
);
  localparam int unsigned NUM_REGS = (1 << SEL_W) - 1;
  localparam int unsigned NUM_RD   = 2;

  logic [NUM_REGS-1:0]             we;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][SEL_W-1:0]    rd_sel;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;
  logic [NUM_RD-1:0]               rd_oe;

  rc_wr_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_i (y_sel_i),
    .we_o  (we)
  );

  rc_reg_array #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (y_data_i),
    .regs_o  (regs)
  );

  assign rd_sel[0] = a_sel_i;
  assign rd_sel[1] = b_sel_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rc_read_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_port (
      .sel_i  (rd_sel[p]),
      .regs_i (regs),
      .data_o (rd_data[p]),
      .oe_o   (rd_oe[p])
    );
  end

  assign a_data_o = rd_data[0];
  assign a_oe_o   = rd_oe[0];
  assign b_data_o = rd_data[1];
  assign b_oe_o   = rd_oe[1];
endmodule

// File: rtl/regfile_card_chk.sv
module regfile_card_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEL_W-1:0]  a_sel_i,
  input logic [SEL_W-1:0]  b_sel_i,
  input logic [SEL_W-1:0]  y_sel_i,
  input logic [DATA_W-1:0] y_data_i,
  input logic [DATA_W-1:0] a_data_o,
  input logic              a_oe_o,
  input logic [DATA_W-1:0] b_data_o,
  input logic              b_oe_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_a_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_sel_i == '0) |-> !a_oe_o);
  assert_b_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_sel_i != '0) |-> b_oe_o);
  assert_a_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_oe_o |-> (a_data_o == '0));
  assert_b_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_o |-> (b_data_o == '0));
  assert_wr_then_rd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(y_sel_i) != '0 && a_sel_i == $past(y_sel_i))
      |-> (a_data_o == $past(y_data_i)));
  assert_no_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(y_sel_i) == '0 && $stable(b_sel_i)) |-> $stable(b_data_o));
endmodule

bind regfile_card regfile_card_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_sel_i  (a_sel_i),
  .b_sel_i  (b_sel_i),
  .y_sel_i  (y_sel_i),
  .y_data_i (y_data_i),
  .a_data_o (a_data_o),
  .a_oe_o   (a_oe_o),
  .b_data_o (b_data_o),
  .b_oe_o   (b_oe_o)
);

// File: tb/regfile_card_test.sv
`timescale 1ns/1ps
module regfile_card_test;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 5;
  localparam int NREG   = (1 << SEL_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [SEL_W-1:0]  a_sel_i = '0, b_sel_i = '0, y_sel_i = '0;
  logic [DATA_W-1:0] y_data_i = '0;
  logic [DATA_W-1:0] a_data_o, b_data_o;
  logic              a_oe_o, b_oe_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  regfile_card #(.DATA_W(DATA_W), .SEL_W(SEL_W)) uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [DATA_W-1:0] pat(int idx, int round);
    return (32'h0101_0101 * idx) ^ (32'h5A00_0000 + round * 32'h0013_0007);
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(int idx, logic [DATA_W-1:0] d);
    @(negedge clk_i);
    y_sel_i = SEL_W'(idx); y_data_i = d;
    @(negedge clk_i);
    y_sel_i = '0;
  endtask

  task automatic readback_all(int round, string req);
    for (int i = 1; i <= NREG; i++) begin
      a_sel_i = SEL_W'(i); b_sel_i = SEL_W'(NREG + 1 - i); #1;
      check({req, " A"}, a_data_o, (round < 0) ? '0 : pat(i, round));
      check({req, " B"}, b_data_o, (round < 0) ? '0 : pat(NREG + 1 - i, round));
      check("R2 oe", {30'd0, a_oe_o, b_oe_o}, 32'd3);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7: reset state
    readback_all(-1, "R7 reset");
    // R2/R3: zero selects release both lanes
    a_sel_i = '0; b_sel_i = '0; #1;
    check("R2 a_oe sel0", {31'd0, a_oe_o}, 32'd0);
    check("R2 b_oe sel0", {31'd0, b_oe_o}, 32'd0);
    // R1: fill all indices, R8 read back both orders
    for (int i = 1; i <= NREG; i++) write(i, pat(i, 1));
    readback_all(1, "R1/R8");
    // R3: released lanes show zero while registers hold nonzero
    a_sel_i = '0; b_sel_i = '0; #1;
    check("R3 a_data", a_data_o, '0);
    check("R3 b_data", b_data_o, '0);
    // R8: same register on both ports
    a_sel_i = 5'd9; b_sel_i = 5'd9; #1;
    check("R8 same A", a_data_o, pat(9, 1));
    check("R8 same B", b_data_o, pat(9, 1));
    // R4: destination zero captures nothing
    @(negedge clk_i); y_sel_i = '0; y_data_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk_i);
    readback_all(1, "R4");
    // R5: combinational select change between edges
    @(negedge clk_i);
    a_sel_i = 5'd3; #2;
    check("R5 sel3", a_data_o, pat(3, 1));
    a_sel_i = 5'd30; #2;
    check("R5 sel30", a_data_o, pat(30, 1));
    // R6: read during write returns old value, new after edge
    @(negedge clk_i);
    a_sel_i = 5'd17; b_sel_i = 5'd17; y_sel_i = 5'd17; y_data_i = 32'h1234_5678; #1;
    check("R6 old A", a_data_o, pat(17, 1));
    check("R6 old B", b_data_o, pat(17, 1));
    @(posedge clk_i); #1;
    check("R6 new A", a_data_o, 32'h1234_5678);
    check("R6 new B", b_data_o, 32'h1234_5678);
    @(negedge clk_i); y_sel_i = '0;
    // R1: second round overwrites every index
    for (int i = 1; i <= NREG; i++) write(i, pat(i, 2));
    readback_all(2, "R1 round2");
    // R7: asynchronous reset between edges
    @(negedge clk_i); #3;
    rst_ni = 1'b0; a_sel_i = 5'd31; b_sel_i = 5'd1; #1;
    check("R7 async A", a_data_o, '0);
    check("R7 async B", b_data_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    readback_all(-1, "R7 after");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule